// File: doc/BRIEF.md
# Power Mode Controller

This block is the finite-state controller that moves a small microcontroller between its run and low-power modes. It gates the CPU clock, the peripheral clock and the system oscillator. It forces the I/O pins to high impedance when needed. It also issues a one-cycle wake pulse that tells the CPU to begin interrupt exception handling. The oscillator, the clock dividers, the CPU core and the RAM retention circuits are outside the block. The block only produces their enables and the peripheral divider select.

There are six states, and each is also the value on the `mode` output: `MD_ACTIVE` (0), `MD_SUBACT` (1), `MD_SLEEP` (2), `MD_STANDBY` (3), `MD_SETTLE` (4) and `MD_RESET` (5). The transitions are:
- reset release: `MD_RESET` to `MD_ACTIVE`.
- enter sleep: `MD_ACTIVE` or `MD_SUBACT` to `MD_SLEEP`, on `sleep_req` with `standby_sel` low.
- enter standby: `MD_ACTIVE` or `MD_SUBACT` to `MD_STANDBY`, on `sleep_req` with `standby_sel` high.
- sleep wake: `MD_SLEEP` to `MD_ACTIVE` or `MD_SUBACT`, on a qualified interrupt.
- oscillator restart: `MD_STANDBY` to `MD_SETTLE`, on a qualified interrupt.
- settle done: `MD_SETTLE` to `MD_ACTIVE` or `MD_SUBACT`, when the settling count expires.
- reset entry: any state to `MD_RESET`, asynchronously, on `rst_n` low.

Both wake transitions pick `MD_SUBACT` when `low_speed_sel` is 1 and `MD_ACTIVE` when it is 0.

An interrupt is qualified only when the global mask `gmask` is 0 and at least one source has both its request bit and its enable bit set. The settling wait lasts 2^(SETTLE_BASE + min(settle_sel, SETTLE_CAP)) cycles. With the defaults this gives 256 cycles at select 0 and 2^19 cycles at select 11 and above.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode` is 5 (reset), `cpu_clk_en`, `periph_clk_en` and `osc_en` are 1, and `io_hiz` and `wake` are 0. On the first clock edge with `rst_n` high, `mode` becomes 0 (active).
- R2: A one-cycle `sleep_req` in active (0) or subactive (1) sets `mode` at the next edge. It becomes 3 (standby) if `standby_sel` is 1 at that edge, and 2 (sleep) otherwise.
- R3: In sleep, `cpu_clk_en` is 0 and `periph_clk_en`, `osc_en` are 1 and `io_hiz` is 0. `periph_div` always equals `div_sel`.
- R4: Source i is qualified when `irq_req[i]` and `irq_en[i]` are 1 and `gmask` is 0. In sleep or standby, a cycle with no qualified source leaves `mode` unchanged.
- R5: A qualified interrupt in sleep moves `mode` at the next edge to 1 (subactive) if `low_speed_sel` is 1 and to 0 (active) if it is 0, with `wake` high in that same cycle.
- R6: In standby, `osc_en`, `cpu_clk_en` and `periph_clk_en` are 0 and `io_hiz` is 1.
- R7: A qualified interrupt in standby moves `mode` to 4 (settling) at the next edge. During settling, `osc_en` is 1, both clock enables are 0 and `io_hiz` is 1. Settling lasts exactly 2^(SETTLE_BASE+`settle_sel`) cycles, with `settle_sel` sampled on entry. It then moves to active or subactive as in R5, with `wake` high.
- R8: A `settle_sel` value from 12 to 15 gives the same settling length as 11.
- R9: `wake` is never high for two cycles in a row.
- R10: Interrupt requests in active or subactive, and both `sleep_req` and interrupts during settling, do not change `mode` or the settling length.
- R11: `rst_n` going low in standby at once gives `mode` 5 with `osc_en` 1 and clocks enabled, without waiting for a clock edge. Release then leads to active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle request from the CPU to enter a low-power mode |
| standby_sel | input | 1 | 1 selects standby, 0 selects sleep on a request |
| low_speed_sel | input | 1 | 1 selects subactive as the wake target |
| div_sel | input | DIV_W | Peripheral clock divider select |
| settle_sel | input | SEL_W | Oscillator settling length select |
| irq_req | input | NUM_SRC | Per-source interrupt requests |
| irq_en | input | NUM_SRC | Per-source interrupt enables |
| gmask | input | 1 | Global interrupt mask, 1 blocks all wake-ups |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| periph_div | output | DIV_W | Divider select forwarded to the peripheral clock divider |
| osc_en | output | 1 | System oscillator enable |
| io_hiz | output | 1 | Forces all I/O ports to high impedance |
| wake | output | 1 | One-cycle pulse that starts interrupt exception handling |
| mode | output | 3 | Current state code (0 to 5) |

## Verification
The assertions check these rules on every cycle:
- the output pattern of the reset, sleep, standby and settling states;
- that a sleep or standby state is held while no source is qualified;
- the sleep wake target and its wake pulse, chosen by `low_speed_sel`;
- that wake is never two cycles long;
- that awake modes stay put without a sleep request.

Only the bench's scenarios can show:
- the exact settling length for a given select and its clamp above 11;
- that requests during settling neither move the state nor stretch the count;
- the asynchronous response to reset in the middle of standby.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        MD_ACTIVE  = 3'd0,
        MD_SUBACT  = 3'd1,
        MD_SLEEP   = 3'd2,
        MD_STANDBY = 3'd3,
        MD_SETTLE  = 3'd4,
        MD_RESET   = 3'd5
    } pmc_mode_e;

endpackage

// File: rtl/pmc_wake_qual.sv
// Decides whether any interrupt source may end a low-power mode.
module pmc_wake_qual #(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               gmask,
    output logic               qual
);

    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = irq_req[g] & irq_en[g];
    end

    assign qual = !gmask && (|hit);

endmodule

// File: rtl/pmc_settle_timer.sv
// Down-counter that measures the oscillator settling window.
module pmc_settle_timer #(
    parameter int BASE  = 8,
    parameter int SEL_W = 4,
    parameter int CAP   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);

    localparam int CNT_W = BASE + CAP + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] init_val;
    logic             run;
    int               eff;

    always_comb begin
        eff      = (int'(sel) > CAP) ? CAP : int'(sel);
        init_val = (CNT_W'(1) << (BASE + eff)) - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            cnt <= init_val;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    assign done = run && (cnt == '0);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int DIV_W       = 3,
    parameter int SEL_W       = 4,
    parameter int SETTLE_BASE = 8,
    parameter int SETTLE_CAP  = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               standby_sel,
    input  logic               low_speed_sel,
    input  logic [DIV_W-1:0]   div_sel,
    input  logic [SEL_W-1:0]   settle_sel,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               gmask,
    output logic               cpu_clk_en,
    output logic               periph_clk_en,
    output logic [DIV_W-1:0]   periph_div,
    output logic               osc_en,
    output logic               io_hiz,
    output logic               wake,
    output logic [2:0]         mode
);

    pmc_mode_e state, state_nxt;
    logic      wake_nxt;
    logic      qual;
    logic      tmr_load;
    logic      tmr_done;
    pmc_mode_e wake_target;

    pmc_wake_qual #(
        .NUM_SRC (NUM_SRC)
    ) u_qual (
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .gmask   (gmask),
        .qual    (qual)
    );

    pmc_settle_timer #(
        .BASE  (SETTLE_BASE),
        .SEL_W (SEL_W),
        .CAP   (SETTLE_CAP)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .sel   (settle_sel),
        .done  (tmr_done)
    );

    assign wake_target = low_speed_sel ? MD_SUBACT : MD_ACTIVE;

    // Next-state decision
    always_comb begin
        state_nxt = state;
        wake_nxt  = 1'b0;
        tmr_load  = 1'b0;
        unique case (state)
            MD_RESET: state_nxt = MD_ACTIVE;
            MD_ACTIVE, MD_SUBACT: begin
                if (sleep_req) begin
                    state_nxt = standby_sel ? MD_STANDBY : MD_SLEEP;
                end
            end
            MD_SLEEP: begin
                if (qual) begin
                    state_nxt = wake_target;
                    wake_nxt  = 1'b1;
                end
            end
            MD_STANDBY: begin
                if (qual) begin
                    state_nxt = MD_SETTLE;
                    tmr_load  = 1'b1;
                end
            end
            MD_SETTLE: begin
                if (tmr_done) begin
                    state_nxt = wake_target;
                    wake_nxt  = 1'b1;
                end
            end
            default: state_nxt = MD_RESET;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= MD_RESET;
            wake  <= 1'b0;
        end else begin
            state <= state_nxt;
            wake  <= wake_nxt;
        end
    end

    // Outputs per state
    always_comb begin
        cpu_clk_en    = 1'b0;
        periph_clk_en = 1'b0;
        osc_en        = 1'b0;
        io_hiz        = 1'b0;
        unique case (state)
            MD_RESET, MD_ACTIVE, MD_SUBACT: begin
                cpu_clk_en    = 1'b1;
                periph_clk_en = 1'b1;
                osc_en        = 1'b1;
            end
            MD_SLEEP: begin
                periph_clk_en = 1'b1;
                osc_en        = 1'b1;
            end
            MD_STANDBY: begin
                io_hiz = 1'b1;
            end
            MD_SETTLE: begin
                osc_en = 1'b1;
                io_hiz = 1'b1;
            end
            default: begin
                osc_en = 1'b1;
            end
        endcase
    end

    assign periph_div = div_sel;
    assign mode       = state;

endmodule

// File: rtl/pmc_chk.sv
module pmc_chk
    import pmc_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sleep_req,
    input logic               low_speed_sel,
    input logic [NUM_SRC-1:0] irq_req,
    input logic [NUM_SRC-1:0] irq_en,
    input logic               gmask,
    input logic               cpu_clk_en,
    input logic               periph_clk_en,
    input logic               osc_en,
    input logic               io_hiz,
    input logic               wake,
    input logic [2:0]         mode
);

    logic any_ok;
    assign any_ok = !gmask && ((irq_req & irq_en) != '0);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_state_r1: assert (mode == MD_RESET && osc_en && !wake && !io_hiz)
                else $error("reset state outputs wrong");
        end
    end

    p_sleep_clocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_SLEEP) |-> (!cpu_clk_en && periph_clk_en && osc_en && !io_hiz));

    p_masked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MD_SLEEP || mode == MD_STANDBY) && !any_ok) |=> (mode == $past(mode)));

    p_sleep_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_SLEEP && any_ok) |=>
            (wake && mode == ($past(low_speed_sel) ? MD_SUBACT : MD_ACTIVE)));

    p_standby_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_STANDBY) |-> (!osc_en && !cpu_clk_en && !periph_clk_en && io_hiz));

    p_settle_osc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_SETTLE) |-> (osc_en && !cpu_clk_en && !periph_clk_en && io_hiz));

    p_wake_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    p_awake_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MD_ACTIVE || mode == MD_SUBACT) && !sleep_req) |=> (mode == $past(mode)));

endmodule

bind pwr_mode_ctrl pmc_chk #(
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_req     (sleep_req),
    .low_speed_sel (low_speed_sel),
    .irq_req       (irq_req),
    .irq_en        (irq_en),
    .gmask         (gmask),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .osc_en        (osc_en),
    .io_hiz        (io_hiz),
    .wake          (wake),
    .mode          (mode)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;

    localparam int NSRC = 8;
    localparam int BASE = 2;

    localparam logic [2:0] M_ACT = 3'd0, M_SUB = 3'd1, M_SLP = 3'd2,
                           M_STB = 3'd3, M_SET = 3'd4, M_RST = 3'd5;
    // outs = {cpu_clk_en, periph_clk_en, osc_en, io_hiz, wake}
    localparam logic [4:0] O_RUN = 5'b11100, O_WAKE = 5'b11101, O_SLEEP = 5'b01100,
                           O_STBY = 5'b00010, O_SETTLE = 5'b00110;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            sleep_req, standby_sel, low_speed_sel, gmask;
    logic [2:0]      div_sel;
    logic [3:0]      settle_sel;
    logic [NSRC-1:0] irq_req, irq_en;
    logic            cpu_clk_en, periph_clk_en, osc_en, io_hiz, wake;
    logic [2:0]      periph_div, mode;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(
        .NUM_SRC     (NSRC),
        .SETTLE_BASE (BASE)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep_req     (sleep_req),
        .standby_sel   (standby_sel),
        .low_speed_sel (low_speed_sel),
        .div_sel       (div_sel),
        .settle_sel    (settle_sel),
        .irq_req       (irq_req),
        .irq_en        (irq_en),
        .gmask         (gmask),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en),
        .periph_div    (periph_div),
        .osc_en        (osc_en),
        .io_hiz        (io_hiz),
        .wake          (wake),
        .mode          (mode)
    );

    typedef struct {
        int         cyc;
        string      req;
        logic [2:0] md;
        logic [4:0] outs;
        logic [2:0] div;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop every due item and compare
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            e = q.pop_front();
            checks++;
            if (e.cyc != cyc || mode !== e.md || periph_div !== e.div ||
                {cpu_clk_en, periph_clk_en, osc_en, io_hiz, wake} !== e.outs) begin
                fails++;
                $display("FAIL %s (cycle %0d): mode=%0d outs=%b div=%0d, expected mode=%0d outs=%b div=%0d",
                         e.req, cyc, mode, {cpu_clk_en, periph_clk_en, osc_en, io_hiz, wake},
                         periph_div, e.md, e.outs, e.div);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic expect_in(input int d, input string r, input logic [2:0] m, input logic [4:0] o);
        exp_t x;
        x.cyc  = cyc + d;
        x.req  = r;
        x.md   = m;
        x.outs = o;
        x.div  = div_sel;
        q.push_back(x);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    localparam int N1  = 1 << (BASE + 1);
    localparam int N13 = 1 << (BASE + 11);

    initial begin
        rst_n = 1'b1; sleep_req = 1'b0; standby_sel = 1'b0; low_speed_sel = 1'b0;
        gmask = 1'b0; div_sel = 3'd1; settle_sel = 4'd0; irq_req = '0; irq_en = '0;
        #1 rst_n = 1'b0;
        step();
        expect_in(1, "R1 reset state", M_RST, O_RUN);
        step(); step();
        rst_n = 1'b1;
        expect_in(1, "R1 release to active", M_ACT, O_RUN);
        step();

        // R10: interrupt while awake is ignored
        irq_req = 8'h01; irq_en = 8'hFF;
        expect_in(1, "R10 irq in active", M_ACT, O_RUN);
        expect_in(2, "R10 irq in active, later", M_ACT, O_RUN);
        step(); irq_req = '0; step();

        // R2/R3: enter sleep
        div_sel = 3'd5;
        sleep_req = 1'b1; standby_sel = 1'b0;
        expect_in(1, "R2 R3 enter sleep", M_SLP, O_SLEEP);
        step(); sleep_req = 1'b0;

        // R4: disabled source, then masked source
        irq_req = 8'h04; irq_en = 8'hFB;
        expect_in(1, "R4 disabled source keeps sleep", M_SLP, O_SLEEP);
        step();
        irq_en = 8'hFF; gmask = 1'b1;
        expect_in(1, "R4 global mask keeps sleep", M_SLP, O_SLEEP);
        step();
        irq_req = '0; gmask = 1'b0;

        // R10: sleep request while asleep
        sleep_req = 1'b1; standby_sel = 1'b1;
        expect_in(1, "R10 sleep_req in sleep", M_SLP, O_SLEEP);
        step(); sleep_req = 1'b0; standby_sel = 1'b0;

        // R5/R9: wake to subactive
        low_speed_sel = 1'b1; irq_req = 8'h10;
        expect_in(1, "R5 sleep to subactive", M_SUB, O_WAKE);
        expect_in(2, "R9 wake single cycle", M_SUB, O_RUN);
        step(); irq_req = '0; step();

        // R2/R6: enter standby from subactive
        div_sel = 3'd2;
        sleep_req = 1'b1; standby_sel = 1'b1;
        expect_in(1, "R2 R6 enter standby", M_STB, O_STBY);
        step(); sleep_req = 1'b0;
        gmask = 1'b1; irq_req = 8'h01;
        expect_in(1, "R4 masked in standby", M_STB, O_STBY);
        step(); gmask = 1'b0; irq_req = '0;

        // R7/R10: settle select 1, requests during settling ignored
        settle_sel = 4'd1; low_speed_sel = 1'b0; irq_req = 8'h80;
        expect_in(1, "R7 settle start", M_SET, O_SETTLE);
        expect_in(3, "R10 requests ignored in settle", M_SET, O_SETTLE);
        expect_in(N1, "R7 settle last cycle", M_SET, O_SETTLE);
        expect_in(N1 + 1, "R7 settle exit to active", M_ACT, O_WAKE);
        expect_in(N1 + 2, "R9 wake drop after settle", M_ACT, O_RUN);
        step(); irq_req = '0;
        step(); sleep_req = 1'b1; irq_req = 8'h80; settle_sel = 4'd5;
        step(); sleep_req = 1'b0; irq_req = '0;
        repeat (N1 - 1) step();

        // R8: select above 11 clamps to 11
        sleep_req = 1'b1; standby_sel = 1'b1;
        expect_in(1, "R8 enter standby", M_STB, O_STBY);
        step(); sleep_req = 1'b0;
        settle_sel = 4'd13; low_speed_sel = 1'b1; irq_req = 8'h02;
        expect_in(1, "R8 settle start", M_SET, O_SETTLE);
        expect_in(N13, "R8 clamped settle last cycle", M_SET, O_SETTLE);
        expect_in(N13 + 1, "R8 R7 clamped exit to subactive", M_SUB, O_WAKE);
        step(); irq_req = '0;
        repeat (N13) step();

        // R5: sleep wake to active
        sleep_req = 1'b1; standby_sel = 1'b0;
        expect_in(1, "R2 enter sleep from subactive", M_SLP, O_SLEEP);
        step(); sleep_req = 1'b0;
        low_speed_sel = 1'b0; irq_req = 8'h20;
        expect_in(1, "R5 sleep to active", M_ACT, O_WAKE);
        step(); irq_req = '0; step();

        // R11: reset in standby
        sleep_req = 1'b1; standby_sel = 1'b1;
        expect_in(1, "R11 enter standby", M_STB, O_STBY);
        step(); sleep_req = 1'b0;
        rst_n = 1'b0;
        #1;
        checks++;
        if (mode !== M_RST || osc_en !== 1'b1 || cpu_clk_en !== 1'b1 || io_hiz !== 1'b0) begin
            fails++;
            $display("FAIL R11 immediate reset: mode=%0d osc=%b cpu=%b hiz=%b, expected mode=5 osc=1 cpu=1 hiz=0",
                     mode, osc_en, cpu_clk_en, io_hiz);
        end
        expect_in(1, "R11 reset held", M_RST, O_RUN);
        step();
        rst_n = 1'b1;
        expect_in(1, "R11 release to active", M_ACT, O_RUN);
        step();
        step();

        done = 1'b1;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL queue drain: %0d items left, expected 0", q.size());
        end
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): run did not end, expected completion");
            summary();
            $finish;
        end
    end

endmodule